// File: doc/BRIEF.md
# Two-Stage Event-to-Host Interrupt Router

This block collects 64 system event inputs and delivers them to 10 host interrupt lines through two programmable many-to-one stages. In the first stage each event is steered to one of 10 intermediate channels. In the second stage each channel is steered to one of the host lines. A rising edge on an event input sets that event's pending bit. The bit stays set until it is cleared through a write-one register. An event takes part in routing only while it is both pending and enabled.

Software controls the block through a 32-bit register bus with word addresses. Writes take effect on the next clock edge. Reads are combinational from the address. Event enables are changed through write-one set and clear registers. A host line is enabled or disabled by writing its index to a set or clear register. A global enable bit gates all host lines. For each host, a priority register reports the pending enabled event that should be serviced first, or a "none" marker when no such event exists.

Top module: `evmap_intc`

## Requirements
- R1: After reset, all host outputs are 0, every map register reads 0, all enable and status registers read 0, and each priority register (word 0x28+h) reads 0x8000_0000.
- R2: A 0-to-1 transition on an event input sets its pending bit whether or not the event is enabled. The bit stays set until it is cleared. An input that stays high does not set the bit again after a clear. Pending bits read back at words 0x06 (events 0..31) and 0x07 (events 32..63).
- R3: Writing a 1 to a bit of word 0x06 or 0x07 clears the matching pending bit, and a 0 leaves the bit unchanged. A rising edge in the same cycle as the clear wins, and the bit remains set.
- R4: Writing ones to words 0x02/0x03 sets event enables (events 0..31 and 32..63), and writing ones to words 0x04/0x05 clears them. Zero bits have no effect. The enables read back at 0x02/0x03.
- R5: The channel of event i is held in word 0x10 + i/4, bits [8*(i%4)+3 : 8*(i%4)]. The upper nibble of each byte is not stored and reads as 0.
- R6: The host of channel j is held in word 0x20 + j/4, bits [8*(j%4)+3 : 8*(j%4)], with the same storage rule as R5.
- R7: Writing index h (0..9) to word 0x08 enables host h, and writing h to word 0x09 disables it. Index values of 10 or more change nothing. The host enable mask reads back in bits [9:0] of word 0x08.
- R8: Bit 0 of word 0x00 is the global enable. While it is 0, every host output is 0.
- R9: Host output h is 1 exactly when the global enable is set, host h is enabled, and some channel c whose host field equals h has at least one pending, enabled event whose channel field equals c.
- R10: Priority register 0x28+h reports the pending enabled event that routes to host h through the lowest-numbered channel, using the lowest event number as a tie-break, with bit 31 equal to 0. When no such event exists the register reads 0x8000_0000. Host enables and the global enable do not affect this register.
- R11: A channel or host field value of 10 or more is stored and read back unchanged, but it routes to nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_in | input | 64 | System event inputs, synchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| host_irq | output | 10 | Host interrupt outputs |

## Verification
A corrupted map field or enable bit shows up within one cycle of the next pending event on the affected route. It appears as a host line that is wrong, and as a priority register that names the wrong event or reports none. A pending bit that is lost or set in error is visible on the status words at once. Once the event is enabled, it also affects host_irq and the priority registers. Because the two routing stages are combinational from registered state, every divergence reaches the ports in the same cycle that the bad state is written.

// File: rtl/evmap_pkg.sv
package evmap_pkg;
  localparam int NUM_EVT   = 64;
  localparam int NUM_CH    = 10;
  localparam int NUM_HOST  = 10;
  localparam int FLD_W     = 4;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 32;

  localparam logic [ADDR_W-1:0] A_GLOB     = 6'h00;
  localparam logic [ADDR_W-1:0] A_EN_SET   = 6'h02;
  localparam logic [ADDR_W-1:0] A_EN_CLR   = 6'h04;
  localparam logic [ADDR_W-1:0] A_STAT_CLR = 6'h06;
  localparam logic [ADDR_W-1:0] A_HEN_SET  = 6'h08;
  localparam logic [ADDR_W-1:0] A_HEN_CLR  = 6'h09;
  localparam logic [ADDR_W-1:0] A_CMAP     = 6'h10;
  localparam logic [ADDR_W-1:0] A_HMAP     = 6'h20;
  localparam logic [ADDR_W-1:0] A_PIDX     = 6'h28;

  localparam logic [DATA_W-1:0] PIDX_NONE  = 32'h8000_0000;
endpackage

// File: rtl/evmap_regs.sv
module evmap_regs
  import evmap_pkg::*;
#(
  parameter int N_EVT  = NUM_EVT,
  parameter int N_CH   = NUM_CH,
  parameter int N_HOST = NUM_HOST
) (
  input  logic                         clk,
  input  logic                         rst_q_n,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [N_EVT-1:0][FLD_W-1:0]  ch_map,
  output logic [N_CH-1:0][FLD_W-1:0]   host_map,
  output logic [N_EVT-1:0]             evt_en,
  output logic [N_HOST-1:0]            host_en,
  output logic                         glob_en,
  output logic [N_EVT-1:0]             stat_clr
);
  localparam int EVT_WORDS = N_EVT / DATA_W;

  logic [N_EVT-1:0][FLD_W-1:0] ch_map_d;
  logic [N_CH-1:0][FLD_W-1:0]  host_map_d;
  logic [N_EVT-1:0]            evt_en_d;
  logic [N_HOST-1:0]           host_en_d;
  logic                        glob_en_d;

  always_comb begin
    ch_map_d   = ch_map;
    host_map_d = host_map;
    evt_en_d   = evt_en;
    host_en_d  = host_en;
    glob_en_d  = glob_en;
    stat_clr   = '0;
    if (we) begin
      if (addr == A_GLOB) glob_en_d = wdata[0];
      for (int k = 0; k < EVT_WORDS; k++) begin
        if (addr == A_EN_SET + ADDR_W'(k))
          evt_en_d[k*DATA_W +: DATA_W] = evt_en[k*DATA_W +: DATA_W] | wdata;
        if (addr == A_EN_CLR + ADDR_W'(k))
          evt_en_d[k*DATA_W +: DATA_W] = evt_en[k*DATA_W +: DATA_W] & ~wdata;
        if (addr == A_STAT_CLR + ADDR_W'(k))
          stat_clr[k*DATA_W +: DATA_W] = wdata;
      end
      for (int h = 0; h < N_HOST; h++) begin
        if (addr == A_HEN_SET && wdata == DATA_W'(h)) host_en_d[h] = 1'b1;
        if (addr == A_HEN_CLR && wdata == DATA_W'(h)) host_en_d[h] = 1'b0;
      end
      for (int e = 0; e < N_EVT; e++)
        if (addr == A_CMAP + ADDR_W'(e / 4))
          ch_map_d[e] = wdata[8*(e%4) +: FLD_W];
      for (int c = 0; c < N_CH; c++)
        if (addr == A_HMAP + ADDR_W'(c / 4))
          host_map_d[c] = wdata[8*(c%4) +: FLD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ch_map   <= '0;
      host_map <= '0;
      evt_en   <= '0;
      host_en  <= '0;
      glob_en  <= 1'b0;
    end else if (we) begin
      ch_map   <= ch_map_d;
      host_map <= host_map_d;
      evt_en   <= evt_en_d;
      host_en  <= host_en_d;
      glob_en  <= glob_en_d;
    end
  end
endmodule

// File: rtl/evmap_latch.sv
module evmap_latch
  import evmap_pkg::*;
#(
  parameter int N_EVT = NUM_EVT
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic [N_EVT-1:0] evt_in,
  input  logic [N_EVT-1:0] stat_clr,
  output logic [N_EVT-1:0] raw_stat,
  output logic [N_EVT-1:0] evt_rise
);
  logic [N_EVT-1:0] prev_q;
  logic [N_EVT-1:0] stat_d;

  always_comb begin
    evt_rise = evt_in & ~prev_q;
    stat_d   = (raw_stat & ~stat_clr) | evt_rise;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      prev_q   <= '0;
      raw_stat <= '0;
    end else begin
      prev_q   <= evt_in;
      raw_stat <= stat_d;
    end
  end
endmodule

// File: rtl/evmap_route.sv
module evmap_route
  import evmap_pkg::*;
#(
  parameter int N_EVT  = NUM_EVT,
  parameter int N_CH   = NUM_CH,
  parameter int N_HOST = NUM_HOST
) (
  input  logic [N_EVT-1:0][FLD_W-1:0]  ch_map,
  input  logic [N_CH-1:0][FLD_W-1:0]   host_map,
  input  logic [N_EVT-1:0]             pend,
  input  logic [N_HOST-1:0]            host_en,
  input  logic                         glob_en,
  output logic [N_HOST-1:0]            host_irq,
  output logic [N_HOST-1:0][DATA_W-1:0] prio_idx
);
  localparam int EIDX_W = $clog2(N_EVT);

  logic [N_CH-1:0]             chan_act;
  logic [N_CH-1:0][EIDX_W-1:0] chan_first;

  // Stage 1: per channel, activity and lowest pending event.
  always_comb begin
    chan_act   = '0;
    chan_first = '0;
    for (int c = 0; c < N_CH; c++) begin
      for (int e = N_EVT - 1; e >= 0; e--) begin
        if (pend[e] && ch_map[e] == FLD_W'(c)) begin
          chan_act[c]   = 1'b1;
          chan_first[c] = EIDX_W'(e);
        end
      end
    end
  end

  // Stage 2: per host, gated output and lowest active channel.
  always_comb begin
    host_irq = '0;
    for (int h = 0; h < N_HOST; h++) begin
      prio_idx[h] = PIDX_NONE;
      for (int c = N_CH - 1; c >= 0; c--) begin
        if (chan_act[c] && host_map[c] == FLD_W'(h)) begin
          prio_idx[h] = DATA_W'(chan_first[c]);
          host_irq[h] = glob_en & host_en[h];
        end
      end
    end
  end
endmodule

// File: rtl/evmap_intc.sv
module evmap_intc
  import evmap_pkg::*;
#(
  parameter int NUM_EVT  = evmap_pkg::NUM_EVT,
  parameter int NUM_CH   = evmap_pkg::NUM_CH,
  parameter int NUM_HOST = evmap_pkg::NUM_HOST
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EVT-1:0]  evt_in,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_HOST-1:0] host_irq
);
  localparam int EVT_WORDS = NUM_EVT / DATA_W;

  logic [1:0]                          rst_pipe;
  logic                                rst_q_n;
  logic [NUM_EVT-1:0][FLD_W-1:0]       ch_map;
  logic [NUM_CH-1:0][FLD_W-1:0]        host_map;
  logic [NUM_EVT-1:0]                  evt_en;
  logic [NUM_HOST-1:0]                 host_en;
  logic                                glob_en;
  logic [NUM_EVT-1:0]                  stat_clr;
  logic [NUM_EVT-1:0]                  raw_stat;
  logic [NUM_EVT-1:0]                  evt_rise;
  logic [NUM_HOST-1:0][DATA_W-1:0]     prio_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  evmap_regs #(.N_EVT(NUM_EVT), .N_CH(NUM_CH), .N_HOST(NUM_HOST)) u_regs (
    .clk(clk), .rst_q_n(rst_q_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .ch_map(ch_map), .host_map(host_map), .evt_en(evt_en), .host_en(host_en),
    .glob_en(glob_en), .stat_clr(stat_clr)
  );

  evmap_latch #(.N_EVT(NUM_EVT)) u_latch (
    .clk(clk), .rst_q_n(rst_q_n), .evt_in(evt_in), .stat_clr(stat_clr),
    .raw_stat(raw_stat), .evt_rise(evt_rise)
  );

  evmap_route #(.N_EVT(NUM_EVT), .N_CH(NUM_CH), .N_HOST(NUM_HOST)) u_route (
    .ch_map(ch_map), .host_map(host_map), .pend(raw_stat & evt_en),
    .host_en(host_en), .glob_en(glob_en), .host_irq(host_irq), .prio_idx(prio_idx)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_GLOB)    bus_rdata[0] = glob_en;
    if (bus_addr == A_HEN_SET) bus_rdata[NUM_HOST-1:0] = host_en;
    for (int k = 0; k < EVT_WORDS; k++) begin
      if (bus_addr == A_EN_SET + ADDR_W'(k))   bus_rdata = evt_en[k*DATA_W +: DATA_W];
      if (bus_addr == A_STAT_CLR + ADDR_W'(k)) bus_rdata = raw_stat[k*DATA_W +: DATA_W];
    end
    for (int e = 0; e < NUM_EVT; e++)
      if (bus_addr == A_CMAP + ADDR_W'(e / 4)) bus_rdata[8*(e%4) +: FLD_W] = ch_map[e];
    for (int c = 0; c < NUM_CH; c++)
      if (bus_addr == A_HMAP + ADDR_W'(c / 4)) bus_rdata[8*(c%4) +: FLD_W] = host_map[c];
    for (int h = 0; h < NUM_HOST; h++)
      if (bus_addr == A_PIDX + ADDR_W'(h)) bus_rdata = prio_idx[h];
  end
endmodule

// File: rtl/evmap_intc_chk.sv
module evmap_intc_chk
  import evmap_pkg::*;
#(
  parameter int NUM_EVT  = evmap_pkg::NUM_EVT,
  parameter int NUM_HOST = evmap_pkg::NUM_HOST
) (
  input logic                            clk,
  input logic                            rst_q_n,
  input logic                            bus_we,
  input logic [ADDR_W-1:0]               bus_addr,
  input logic [DATA_W-1:0]               bus_wdata,
  input logic [NUM_HOST-1:0]             host_irq,
  input logic [NUM_HOST-1:0][DATA_W-1:0] prio_idx,
  input logic [NUM_EVT-1:0]              evt_rise,
  input logic [NUM_EVT-1:0]              raw_stat
);
  AST_GLOBAL_GATES: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_we && bus_addr == A_GLOB && !bus_wdata[0]) |=> (host_irq == '0)); // R8

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> (($past(evt_rise) & ~raw_stat) == '0)); // R2

  for (genvar h = 0; h < NUM_HOST; h++) begin : g_host
    AST_HOST_DISABLE: assert property (@(posedge clk) disable iff (!rst_q_n)
      (bus_we && bus_addr == A_HEN_CLR && bus_wdata == DATA_W'(h)) |=> !host_irq[h]); // R7

    AST_IRQ_HAS_INDEX: assert property (@(posedge clk) disable iff (!rst_q_n)
      host_irq[h] |-> !prio_idx[h][31]); // R10
  end
endmodule

bind evmap_intc evmap_intc_chk #(.NUM_EVT(NUM_EVT), .NUM_HOST(NUM_HOST)) u_chk (.*);

// File: tb/evmap_intc_test.sv
module evmap_intc_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] evt = '0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [9:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [63:0] m_en, m_st, m_prev;
  logic [3:0]  m_cm [64];
  logic [3:0]  m_hm [10];
  logic [9:0]  m_hen;
  logic        m_glob;

  evmap_intc uut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .host_irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_idx(int h);
    logic [63:0] pend = m_st & m_en;
    for (int c = 0; c < 10; c++)
      if (m_hm[c] == 4'(h))
        for (int e = 0; e < 64; e++)
          if (pend[e] && m_cm[e] == 4'(c)) return 32'(e);
    return 32'h8000_0000;
  endfunction

  function automatic logic [9:0] exp_irq();
    logic [9:0] r = '0;
    for (int h = 0; h < 10; h++)
      if (m_glob && m_hen[h] && !exp_idx(h)[31]) r[h] = 1'b1;
    return r;
  endfunction

  task automatic tick();
    logic [63:0] rise;
    logic [63:0] clr;
    @(posedge clk);
    #1;
    rise = evt & ~m_prev;
    clr = '0;
    if (we) begin
      if (addr == 6'h00) m_glob = wdata[0];
      if (addr == 6'h02) m_en[31:0]  |= wdata;
      if (addr == 6'h03) m_en[63:32] |= wdata;
      if (addr == 6'h04) m_en[31:0]  &= ~wdata;
      if (addr == 6'h05) m_en[63:32] &= ~wdata;
      if (addr == 6'h06) clr[31:0]  = wdata;
      if (addr == 6'h07) clr[63:32] = wdata;
      if (addr == 6'h08 && wdata < 10) m_hen[wdata[3:0]] = 1'b1;
      if (addr == 6'h09 && wdata < 10) m_hen[wdata[3:0]] = 1'b0;
      if (addr >= 6'h10 && addr <= 6'h1F)
        for (int b = 0; b < 4; b++) m_cm[(int'(addr) - 16) * 4 + b] = wdata[8*b +: 4];
      if (addr >= 6'h20 && addr <= 6'h22)
        for (int b = 0; b < 4; b++)
          if ((int'(addr) - 32) * 4 + b < 10) m_hm[(int'(addr) - 32) * 4 + b] = wdata[8*b +: 4];
    end
    m_st = (m_st & ~clr) | rise;
    m_prev = evt;
    we = 1'b0;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic check_ports(string req);
    logic [31:0] v;
    check(req, 32'(irq), 32'(exp_irq()));
    for (int h = 0; h < 10; h++) begin
      rd(6'h28 + 6'(h), v);
      check("R10 priority index", v, exp_idx(h));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    m_en = '0; m_st = '0; m_prev = '0; m_hen = '0; m_glob = 1'b0;
    for (int e = 0; e < 64; e++) m_cm[e] = '0;
    for (int c = 0; c < 10; c++) m_hm[c] = '0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();

    // R1: reset state
    check("R1 host_irq", 32'(irq), 32'h0);
    rd(6'h28, v); check("R1 prio idx", v, 32'h8000_0000);
    rd(6'h13, v); check("R1 map", v, 32'h0);
    rd(6'h02, v); check("R1 enables", v, 32'h0);
    rd(6'h06, v); check("R1 status", v, 32'h0);

    // R5: channel map field layout, upper nibble dropped
    wr(6'h13, 32'hAF19_2533);
    rd(6'h13, v); check("R5 map readback", v, 32'h0F09_0503);
    // event 13 -> channel 5 ; R6: channel 5 -> host 7 (word 0x21 byte 1)
    wr(6'h21, 32'h0000_0700);
    rd(6'h21, v); check("R6 map readback", v, 32'h0000_0700);
    wr(6'h02, 32'h0000_2000);            // R4 enable event 13
    rd(6'h02, v); check("R4 enable readback", v, 32'h0000_2000);
    wr(6'h08, 32'd7);                    // R7 enable host 7
    wr(6'h08, 32'd12);                   // R7 out-of-range index ignored
    rd(6'h08, v); check("R7 host mask", v, 32'h0000_0080);
    evt[13] = 1'b1;
    tick();
    check("R8 global off", 32'(irq), 32'h0);
    rd(6'h06, v); check("R2 latched", v, 32'h0000_2000);
    wr(6'h00, 32'h1);                    // R8 global on
    check("R9 routed", 32'(irq), 32'h0000_0080);
    rd(6'h2F, v); check("R10 index host7", v, 32'd13);

    // R2: level held, clear, no relatch
    wr(6'h06, 32'h0000_2000);
    tick();
    rd(6'h06, v); check("R2 no relatch on level", v, 32'h0);
    check("R3 cleared irq", 32'(irq), 32'h0);
    // R3: set wins over clear in same cycle; zero bits ignored
    evt[13] = 1'b0; tick();
    evt[13] = 1'b1; wr(6'h06, 32'h0000_2000);
    rd(6'h06, v); check("R3 set wins", v, 32'h0000_2000);
    wr(6'h06, 32'h0);
    rd(6'h06, v); check("R3 zero write", v, 32'h0000_2000);
    // R11: channel field 12 routes nowhere but reads back
    wr(6'h13, 32'h0000_0C00);
    rd(6'h13, v); check("R11 readback", v, 32'h0000_0C00);
    check("R11 no route", 32'(irq), 32'h0);
    rd(6'h2F, v); check("R11 no index", v, 32'h8000_0000);
    // R7: disable host 7 while routed
    wr(6'h13, 32'h0000_0500);
    check("R9 reroute", 32'(irq), 32'h0000_0080);
    wr(6'h09, 32'd7);
    check("R7 host disabled", 32'(irq), 32'h0);
    rd(6'h2F, v); check("R10 index independent of enable", v, 32'd13);

    // enable all hosts for richer random traffic
    for (int h = 0; h < 10; h++) wr(6'h08, 32'(h));
    for (int it = 0; it < 2500; it++) begin
      int op = $urandom_range(0, 11);
      if ($urandom_range(0, 2) == 0) evt ^= 64'(1) << $urandom_range(0, 63);
      case (op)
        0: wr(6'h00, 32'($urandom_range(0, 4) != 0));
        1, 2: wr(6'h02 + 6'($urandom_range(0, 1)), $urandom & $urandom);
        3: wr(6'h04 + 6'($urandom_range(0, 1)), $urandom & $urandom & $urandom);
        4: wr(6'h06 + 6'($urandom_range(0, 1)), $urandom & $urandom);
        5: wr(6'h08, 32'($urandom_range(0, 11)));
        6: wr(6'h09, 32'($urandom_range(0, 11)));
        7, 8: wr(6'h10 + 6'($urandom_range(0, 15)), $urandom & 32'h0F0F_0F0F);
        9: wr(6'h20 + 6'($urandom_range(0, 2)), $urandom);
        default: tick();
      endcase
      check("R9 host_irq", 32'(irq), 32'(exp_irq()));
      rd(6'h28 + 6'($urandom_range(0, 9)), v);
      check("R10 priority index", v, exp_idx(int'(addr) - 40));
      if (it % 16 == 0) begin
        rd(6'h06, v); check("R2 status lo", v, m_st[31:0]);
        rd(6'h07, v); check("R3 status hi", v, m_st[63:32]);
        rd(6'h03, v); check("R4 enable hi", v, m_en[63:32]);
        rd(6'h08, v); check("R7 host mask", v, 32'(m_hen));
        rd(6'h20 + 6'($urandom_range(0, 2)), v);
        check("R6 host map", v,
              {4'h0, (int'(addr)-32)*4+3 < 10 ? m_hm[(int'(addr)-32)*4+3] : 4'h0,
               4'h0, (int'(addr)-32)*4+2 < 10 ? m_hm[(int'(addr)-32)*4+2] : 4'h0,
               4'h0, m_hm[(int'(addr)-32)*4+1], 4'h0, m_hm[(int'(addr)-32)*4]});
      end
      if (it % 250 == 0) check_ports("R11 sweep");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule